// File: doc/BRIEF.md
# Fractional Sample-Rate Converter with Gap Timing Hold

The block takes signed samples whose rate depends on the selected band. They arrive from a decimate-by-24 stage, so a 312 MHz converter clock arrives here as 13 MHz. The front end can span about 289 to 362 MHz. The block re-times these samples to a fixed 13 MHz-equivalent output stream.

A 32-bit phase accumulator sets the interpolation point. Each output adds a programmable step to the accumulator. The step equals the input-to-output rate ratio in units of 2^-32 input samples. The carry out of the accumulator tells the block how many fresh samples it must shift in before the next output. The top 12 fraction bits form the fractional delay mu. A cubic Lagrange interpolator in Horner (Farrow) form evaluates the point between the middle two of four held samples.

The radio can shut down or change band. For that case a gap request hands timing to a stable reference tick. While the gap lasts, the accumulator keeps advancing by a separate programmable reference step, and no outputs are produced. The gap is entered and left only on a strobe that marks a submultiple of the band clock. After the gap, the block refills its four-sample history and resumes from the carried-over phase, with no phase reset. The downstream path searcher therefore keeps its timing within a small fraction of a chip.

Top module: `frc_top`

## Requirements
- R1: While rst_ni is low and after it is released, out_valid_o is 0 and the phase accumulator is 0. No output appears before four samples have been shifted in.
- R2: The sample history is four deep and ordered in time, s0 oldest to s3 newest. Outputs interpolate between s1 and s2 at fraction mu = acc[31:20]/4096. With the accumulator at 0, the first output after reset equals s1, the second of the first four samples.
- R3: Each output adds step_i, a 33-bit unsigned value with 2^32 meaning one input sample, to the 32-bit accumulator. The carry (0, 1 or 2) is the number of samples to shift in before the next output. An output is registered one cycle after a cycle in which four samples are held, no shift is pending and no gap is active.
- R4: Each output is the cubic Lagrange value over s0..s3 at mu, to within 2 LSB. The Lagrange nodes sit at positions -1, 0, 1 and 2 relative to s1.
- R5: Results above 32767 give 32767, and results below -32768 give -32768.
- R6: When all four held samples are equal, the output equals that value exactly.
- R7: A sample is discarded, with no effect on the history or on later outputs, if it arrives in a cycle that emits an output, or while four samples are held with no shift pending, or during a gap.
- R8: The gap state takes the value of gap_req_i only in cycles where edge_sync_i is 1. A change of gap_req_i at any other time has no effect.
- R9: During a gap, no output is produced. The accumulator adds ref_step_i (32-bit, carry discarded) on each ref_tick_i and holds otherwise.
- R10: After a gap ends, the history is empty and the pending-shift count is 0. The first output follows four new samples and uses the accumulator value carried over from the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 16 | Signed input sample |
| step_i | input | 33 | Accumulator step per output (2^32 = one input sample) |
| ref_step_i | input | 32 | Accumulator step per reference tick during a gap |
| gap_req_i | input | 1 | Requested gap state |
| edge_sync_i | input | 1 | Band-clock submultiple strobe; gap state may change here |
| ref_tick_i | input | 1 | Stable reference tick used during a gap |
| out_valid_o | output | 1 | Output sample strobe |
| out_data_o | output | 16 | Signed rounded and saturated output sample |

## Verification
A wrong pending-shift count or fill count shows up at the ports within one output interval: an output is added, missed or shifted by a cycle. A misordered history or a wrong mu bit slice gives interpolated values off by far more than 2 LSB on a sine at the next output. A phase that is reset or frozen across a gap gives no symptom during the gap. It appears on the fourth sample after the gap, as an output whose value and position in time differ from those of a phase that kept running.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int DATA_W_DEF = 16;
  localparam int ACC_W_DEF  = 32;
  localparam int MU_W_DEF   = 12;
  localparam int N_TAPS     = 4;   // cubic
  localparam int NEED_W     = 2;   // carry of acc + step, step < 2 samples
  localparam int GUARD_W    = 10;  // headroom for 6x scaled Farrow terms
endpackage

// File: rtl/frc_taps.sv
module frc_taps #(
  parameter int DATA_W = 16,
  parameter int TAPS   = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         shift_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [TAPS-1:0][DATA_W-1:0]  taps_o
);
  // taps_o[0] newest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      taps_o[0] <= '0;
    else if (shift_i) taps_o[0] <= data_i;
  end

  for (genvar i = 1; i < TAPS; i++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      taps_o[i] <= '0;
      else if (shift_i) taps_o[i] <= taps_o[i-1];
    end
  end
endmodule

// File: rtl/frc_phase_ctrl.sv
module frc_phase_ctrl
  import frc_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int MU_W  = 12,
  parameter int TAPS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [ACC_W:0]    step_i,
  input  logic [ACC_W-1:0]  ref_step_i,
  input  logic              gap_req_i,
  input  logic              edge_sync_i,
  input  logic              ref_tick_i,
  output logic              emit_o,
  output logic              shift_o,
  output logic [MU_W-1:0]   mu_o,
  output logic              gap_o,
  output logic              full_o
);
  localparam int FILL_W = $clog2(TAPS + 1);
  localparam int SUM_W  = ACC_W + NEED_W;

  logic [ACC_W-1:0]  acc_q;
  logic [NEED_W-1:0] need_q;
  logic [FILL_W-1:0] fill_q;
  logic              gap_q;
  logic [SUM_W-1:0]  sum_out;

  assign full_o  = (fill_q == FILL_W'(TAPS));
  assign emit_o  = !gap_q && full_o && (need_q == '0);
  assign shift_o = !gap_q && !emit_o && in_valid_i && (!full_o || need_q != '0);
  assign mu_o    = acc_q[ACC_W-1 -: MU_W];
  assign gap_o   = gap_q;
  assign sum_out = {{(NEED_W-1){1'b0}}, step_i} + {{NEED_W{1'b0}}, acc_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      need_q <= '0;
      fill_q <= '0;
      gap_q  <= 1'b0;
    end else begin
      if (edge_sync_i) gap_q <= gap_req_i;
      if (gap_q) begin
        fill_q <= '0;
        need_q <= '0;
        if (ref_tick_i) acc_q <= acc_q + ref_step_i;
      end else if (emit_o) begin
        acc_q  <= sum_out[ACC_W-1:0];
        need_q <= sum_out[ACC_W +: NEED_W];
      end else if (shift_o) begin
        if (!full_o) fill_q <= fill_q + FILL_W'(1);
        else         need_q <= need_q - NEED_W'(1);
      end
    end
  end

  p_need_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    need_q <= NEED_W'(2));
  p_gap_sync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(edge_sync_i) |-> $stable(gap_q));
  p_acc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q && !ref_tick_i |=> $stable(acc_q));
  p_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q |=> !full_o);
endmodule

// File: rtl/frc_farrow.sv
module frc_farrow
  import frc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MU_W   = 12,
  parameter int TAPS   = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        emit_i,
  input  logic [TAPS-1:0][DATA_W-1:0] taps_i,
  input  logic [MU_W-1:0]             mu_i,
  output logic                        out_valid_o,
  output logic [DATA_W-1:0]           out_data_o
);
  localparam int W = DATA_W + GUARD_W;
  localparam logic signed [W-1:0] C3   = W'(3);
  localparam logic signed [W-1:0] C6   = W'(6);
  localparam logic signed [W-1:0] MAXV = W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [W-1:0] MINV = -W'(1 << (DATA_W - 1));

  function automatic logic signed [W-1:0] x2(input logic signed [W-1:0] a);
    return a <<< 1;
  endfunction
  function automatic logic signed [W-1:0] x3(input logic signed [W-1:0] a);
    return (a <<< 1) + a;
  endfunction
  function automatic logic signed [W-1:0] x6(input logic signed [W-1:0] a);
    return (a <<< 2) + (a <<< 1);
  endfunction

  logic signed [MU_W:0]    mu_s;
  logic signed [W-1:0]     s0, s1, s2, s3;
  logic signed [W-1:0]     k0, k1, k2, k3;
  logic signed [W-1:0]     h3, h2, h1, q, q_sat;
  logic signed [W+MU_W:0]  p3, p2, p1;

  // history: s0 oldest, s3 newest; output between s1 and s2
  assign s0 = W'($signed(taps_i[3]));
  assign s1 = W'($signed(taps_i[2]));
  assign s2 = W'($signed(taps_i[1]));
  assign s3 = W'($signed(taps_i[0]));
  assign mu_s = $signed({1'b0, mu_i});

  // coefficients scaled by 6
  assign k3 = s3 - s0 + x3(s1) - x3(s2);
  assign k2 = x3(s0) - x6(s1) + x3(s2);
  assign k1 = x6(s2) - x2(s0) - x3(s1) - s3;
  assign k0 = x6(s1);

  assign p3 = k3 * mu_s;
  assign h3 = W'(p3 >>> MU_W) + k2;
  assign p2 = h3 * mu_s;
  assign h2 = W'(p2 >>> MU_W) + k1;
  assign p1 = h2 * mu_s;
  assign h1 = W'(p1 >>> MU_W) + k0;

  always_comb begin
    if (h1 >= 0) q = (h1 + C3) / C6;
    else         q = -((C3 - h1) / C6);
    if (q > MAXV)      q_sat = MAXV;
    else if (q < MINV) q_sat = MINV;
    else               q_sat = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= emit_i;
      if (emit_i) out_data_o <= DATA_W'(q_sat);
    end
  end

  p_dc_exact_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_i && taps_i[0] == taps_i[1] && taps_i[1] == taps_i[2] && taps_i[2] == taps_i[3]
    |=> out_data_o == $past(taps_i[0]));
  p_valid_tracks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emit_i |=> !out_valid_o);
endmodule

// File: rtl/frc_top.sv
module frc_top
  import frc_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int ACC_W  = ACC_W_DEF,
  parameter int MU_W   = MU_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [ACC_W:0]    step_i,
  input  logic [ACC_W-1:0]  ref_step_i,
  input  logic              gap_req_i,
  input  logic              edge_sync_i,
  input  logic              ref_tick_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  logic                          emit, shift, gap, full;
  logic [MU_W-1:0]               mu;
  logic [N_TAPS-1:0][DATA_W-1:0] taps;

  frc_phase_ctrl #(.ACC_W(ACC_W), .MU_W(MU_W), .TAPS(N_TAPS)) u_phase (
    .clk_i, .rst_ni, .in_valid_i, .step_i, .ref_step_i, .gap_req_i,
    .edge_sync_i, .ref_tick_i,
    .emit_o(emit), .shift_o(shift), .mu_o(mu), .gap_o(gap), .full_o(full)
  );

  frc_taps #(.DATA_W(DATA_W), .TAPS(N_TAPS)) u_taps (
    .clk_i, .rst_ni, .shift_i(shift), .data_i(in_data_i), .taps_o(taps)
  );

  frc_farrow #(.DATA_W(DATA_W), .MU_W(MU_W), .TAPS(N_TAPS)) u_farrow (
    .clk_i, .rst_ni, .emit_i(emit), .taps_i(taps), .mu_i(mu),
    .out_valid_o, .out_data_o
  );

  p_quiet_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap |=> !out_valid_o);
  p_primed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(full));
endmodule

// File: tb/frc_top_test.sv
module frc_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [32:0] step = '0;
  logic [31:0] ref_step = '0;
  logic        gap_req = 1'b0, edge_sync = 1'b0, ref_tick = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;

  int    checks = 0, fails = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  frc_top uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .step_i(step), .ref_step_i(ref_step), .gap_req_i(gap_req),
    .edge_sync_i(edge_sync), .ref_tick_i(ref_tick),
    .out_valid_o(out_valid), .out_data_o(out_data)
  );

  // behavioural reference
  longint m_acc = 0;
  int     m_need = 0, m_fill = 0;
  bit     m_gap = 0;
  int     hist[$];   // hist[0] oldest
  bit     exp_v = 0;
  int     exp_d = 0;

  function automatic int lagrange(int a, int b, int c, int d, longint acc);
    real mu, y;
    int  r;
    mu = real'((acc >> 20) & 4095) / 4096.0;
    y  = -mu * (mu - 1.0) * (mu - 2.0) / 6.0 * a
       + (mu + 1.0) * (mu - 1.0) * (mu - 2.0) / 2.0 * b
       - (mu + 1.0) * mu * (mu - 2.0) / 2.0 * c
       + (mu + 1.0) * mu * (mu - 1.0) / 6.0 * d;
    r = int'(y);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_need = 0; m_fill = 0; m_gap = 0; exp_v = 0; hist = {};
    end else begin
      bit emit;
      longint sum;
      emit = !m_gap && m_fill == 4 && m_need == 0;
      exp_v = emit;
      if (emit) exp_d = lagrange(hist[0], hist[1], hist[2], hist[3], m_acc);
      if (m_gap) begin
        if (ref_tick) m_acc = (m_acc + longint'(ref_step)) & 64'hFFFF_FFFF;
        m_fill = 0; m_need = 0; hist = {};
      end else if (emit) begin
        sum = m_acc + longint'(step);
        m_acc = sum & 64'hFFFF_FFFF;
        m_need = int'(sum >> 32);
      end else if (in_valid && (m_fill < 4 || m_need > 0)) begin
        hist.push_back(int'($signed(in_data)));
        if (hist.size() > 4) void'(hist.pop_front());
        if (m_fill < 4) m_fill++;
        else m_need--;
      end
      if (edge_sync) m_gap = gap_req;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (out_valid !== exp_v) begin
        fails++;
        $display("FAIL %s: out_valid=%0b expected %0b at %0t", cur_req, out_valid, exp_v, $time);
      end else if (exp_v) begin
        int d;
        checks++;
        d = int'($signed(out_data)) - exp_d;
        if (d > 2 || d < -2) begin
          fails++;
          $display("FAIL %s: out_data=%0d expected %0d at %0t", cur_req,
                   $signed(out_data), exp_d, $time);
        end
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic logic [15:0] gen(int kind, int i);
    case (kind)
      0: return 16'(int'(20000.0 * $sin(0.21 * i)));
      1: return 16'(1234);
      2: return (((i + 1) % 4) < 2) ? 16'h8000 : 16'h7FFF;  // -A,A,A,-A pattern
      default: return 16'(i * 97 - 3000);
    endcase
  endfunction

  function automatic logic [32:0] ratio(real fin_mhz);
    return 33'(longint'(fin_mhz / 312.0 * 4294967296.0));
  endfunction

  int sidx = 0;
  // n cycles; sample every in_per cycles; tick every tick_per; sync pulse at cycle sync_at
  task automatic run(int n, int in_per, int kind, int tick_per, int sync_at);
    for (int c = 0; c < n; c++) begin
      @(negedge clk); #0.5;
      in_valid  = (in_per > 0) && (c % in_per == 0);
      if (in_valid) begin in_data = gen(kind, sidx); sidx++; end
      ref_tick  = (tick_per > 0) && (c % tick_per == 0);
      edge_sync = (c == sync_at);
    end
    @(negedge clk); #0.5;
    in_valid = 0; ref_tick = 0; edge_sync = 0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: out_valid=%0b expected 0 in reset", out_valid);
    end
    #0.5 rst_n = 1'b1;
    step = ratio(312.0);
    cur_req = "R1"; run(10, 0, 0, 0, -1);     // no samples: no output
    cur_req = "R2"; run(40, 3, 3, 0, -1);
    cur_req = "R4"; step = ratio(289.0); run(600, 3, 0, 0, -1);
    cur_req = "R3"; step = ratio(362.0); run(600, 2, 0, 0, -1);
    cur_req = "R6"; step = ratio(300.0); run(400, 3, 1, 0, -1);
    cur_req = "R5"; step = ratio(312.0) >> 1; run(400, 3, 2, 0, -1);
    cur_req = "R7"; step = ratio(330.0); run(300, 1, 0, 0, -1);
    cur_req = "R8"; gap_req = 1; run(200, 3, 0, 7, -1); gap_req = 0;
    cur_req = "R9"; ref_step = 32'h2345_6789; gap_req = 1;
    run(300, 3, 0, 5, 4);
    cur_req = "R10"; gap_req = 0; run(10, 0, 0, 5, 2);
    run(600, 3, 0, 0, -1);
    step = ratio(350.0); run(400, 2, 3, 0, -1);
    repeat (4) @(negedge clk);
    report();
  end
endmodule